// File: doc/BRIEF.md
# Crosspoint Control Pulse Generator

This block is the hardwired control decoder of a small accumulator datapath. For each clock it takes the code of the subinstruction being executed and the number of the current time step within the twelve-step memory cycle. From these two inputs it produces the datapath control pulses for that step. There is no stored control program. Decoding has two stages. First, a group signal that stands for one or more related subinstructions is ANDed with a one-hot time step. This gives a set of intermediate crosspoint signals. Second, each crosspoint fans out to one or more control pulses, and every control pulse is the OR of all crosspoints that may request it.

The single-word add-to-storage subinstruction and the second subinstruction of the double-word add both select the same group term. They therefore reuse one set of crosspoints. Seven placeholder subinstructions each own a single crosspoint at one step. Each of these crosspoints requests only the accumulator-to-adder-X pulse. Together with the add group's step-5 crosspoint, that pulse has eight sources. Both the crosspoint vector and the pulse vector are registered and exposed, so that each of the two stages can be observed on its own.

Top module: `xpt_ctrl_gen`

## Requirements
- R1: While rst_n is low, xpoint and ctrl_pulse are all zero.
- R2: The outputs follow the inputs with one clock of latency. The values seen after a rising edge belong to the sub_code and time_step sampled at that edge, and they hold until the next edge.
- R3: Codes 1 (add-to-storage) and 2 (second word of double add) produce identical xpoint and ctrl_pulse values at every time step, because both select the shared add group.
- R4: Under the add group at step 5, crosspoint bits 1 and 2 are both set. Crosspoint 1 drives ctrl_pulse bits 0 (accumulator to adder X) and 1 (read data register). Crosspoint 2 drives bit 2 (write adder Y). ctrl_pulse is then 0x007 and xpoint is 0x0006.
- R5: Under the add group, the other steps give these values. Step 1 sets crosspoint 0 and pulses 3 (read buffer) and 4 (write address), giving 0x018. Step 6 sets crosspoint 3 and pulses 5 (read sum) and 6 (write data register), giving 0x060. Step 8 sets crosspoint 4 and pulses 7 (read program counter) and 4, giving 0x090. Step 11 sets crosspoint 5 and pulses 5 and 8 (write accumulator), giving 0x120. Steps 2, 3, 4, 7, 9, 10 and 12 give all zeros.
- R6: For k from 0 to 6, code 3+k at step 2+k sets only crosspoint 6+k and only ctrl_pulse bit 0. That pulse is thus the OR of eight crosspoints: crosspoint 1 and crosspoints 6 to 12.
- R7: Codes with no defined row (0 and 10 to 15) give all-zero outputs at every time step.
- R8: Time step values outside 1..12 (0, 13, 14, 15) give all-zero outputs for every code.
- R9: A placeholder code at any step other than its own gives all-zero outputs.
- R10: At most two crosspoints are active at once. Each outputs vector is a pure function of the sampled inputs, with no dependence on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_code | input | 4 | Current subinstruction code |
| time_step | input | 4 | Current time step, 1 to 12 valid |
| xpoint | output | 13 | Registered intermediate crosspoint vector |
| ctrl_pulse | output | 9 | Registered datapath control pulses |

## Verification
The add-to-storage code is walked through all sixteen step values. This separates the five active steps from the silent ones, and it exposes any pulse assigned to the wrong step or to the wrong crosspoint. The double-add code is then run over the same steps and compared with the add-to-storage results, which shows whether the group term is really shared. Each placeholder code is tried at its own step and at a neighbouring step. This tells a correct eight-way OR apart from a missing source, and it also catches a placeholder that leaks into another step. Finally, a sweep over every code and step value against an independent model catches stray decodes of undefined codes and of out-of-range steps, and a mid-cycle sample confirms the single register of latency.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

   // control pulse bit positions
   localparam int PL_ACC_TO_X = 0;
   localparam int PL_RD_MDR   = 1;
   localparam int PL_WR_Y     = 2;
   localparam int PL_RD_BUF   = 3;
   localparam int PL_WR_ADDR  = 4;
   localparam int PL_RD_SUM   = 5;
   localparam int PL_WR_MDR   = 6;
   localparam int PL_RD_PC    = 7;
   localparam int PL_WR_ACC   = 8;
   localparam int NUM_PULSES  = 9;

   // crosspoints owned by the shared add group
   localparam int XP_ADD_T1  = 0;
   localparam int XP_ADD_T5A = 1;
   localparam int XP_ADD_T5B = 2;
   localparam int XP_ADD_T6  = 3;
   localparam int XP_ADD_T8  = 4;
   localparam int XP_ADD_T11 = 5;
   localparam int ADD_XP_COUNT = 6;

   // group index of a crosspoint: 0 is the add group, then one per placeholder
   function automatic int xp_group(input int xp);
      return (xp < ADD_XP_COUNT) ? 0 : xp - ADD_XP_COUNT + 1;
   endfunction

   // time step (1-based) at which a crosspoint fires
   function automatic int xp_step(input int xp, input int aux_base_step);
      case (xp)
         XP_ADD_T1:  return 1;
         XP_ADD_T5A: return 5;
         XP_ADD_T5B: return 5;
         XP_ADD_T6:  return 6;
         XP_ADD_T8:  return 8;
         XP_ADD_T11: return 11;
         default:    return aux_base_step + xp - ADD_XP_COUNT;
      endcase
   endfunction

   // fan-out: does crosspoint xp request pulse pl
   function automatic bit xp_drives(input int xp, input int pl);
      case (xp)
         XP_ADD_T1:  return (pl == PL_RD_BUF) || (pl == PL_WR_ADDR);
         XP_ADD_T5A: return (pl == PL_ACC_TO_X) || (pl == PL_RD_MDR);
         XP_ADD_T5B: return (pl == PL_WR_Y);
         XP_ADD_T6:  return (pl == PL_RD_SUM) || (pl == PL_WR_MDR);
         XP_ADD_T8:  return (pl == PL_RD_PC) || (pl == PL_WR_ADDR);
         XP_ADD_T11: return (pl == PL_RD_SUM) || (pl == PL_WR_ACC);
         default:    return (pl == PL_ACC_TO_X);
      endcase
   endfunction

endpackage

// File: rtl/xpt_group_dec.sv
module xpt_group_dec #(
   parameter int SUB_W         = 4,
   parameter int NUM_AUX       = 7,
   parameter int ADS_CODE      = 1,
   parameter int DAS_CODE      = 2,
   parameter int AUX_BASE_CODE = 3
) (
   input  logic [SUB_W-1:0]   sub_i,
   output logic [NUM_AUX:0]   grp_o
);

   // shared add group: both add subinstructions map onto one term
   assign grp_o[0] = (sub_i == SUB_W'(ADS_CODE)) | (sub_i == SUB_W'(DAS_CODE));

   for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
      assign grp_o[g+1] = (sub_i == SUB_W'(AUX_BASE_CODE + g));
   end

endmodule

// File: rtl/xpt_step_dec.sv
module xpt_step_dec #(
   parameter int STEP_W    = 4,
   parameter int NUM_STEPS = 12
) (
   input  logic [STEP_W-1:0]    step_i,
   output logic [NUM_STEPS-1:0] step_o
);

   for (genvar s = 0; s < NUM_STEPS; s++) begin : g_step
      assign step_o[s] = (step_i == STEP_W'(s + 1));
   end

endmodule

// File: rtl/xpt_cross_and.sv
module xpt_cross_and
   import xpt_pkg::*;
#(
   parameter int NUM_AUX       = 7,
   parameter int NUM_STEPS     = 12,
   parameter int AUX_BASE_STEP = 2,
   localparam int NUM_GROUPS   = NUM_AUX + 1,
   localparam int NUM_XP       = ADD_XP_COUNT + NUM_AUX
) (
   input  logic [NUM_GROUPS-1:0] grp_i,
   input  logic [NUM_STEPS-1:0]  step_i,
   output logic [NUM_XP-1:0]     xp_o
);

   for (genvar x = 0; x < NUM_XP; x++) begin : g_xp
      localparam int GRP  = xp_group(x);
      localparam int STEP = xp_step(x, AUX_BASE_STEP);
      assign xp_o[x] = grp_i[GRP] & step_i[STEP-1];
   end

endmodule

// File: rtl/xpt_pulse_or.sv
module xpt_pulse_or
   import xpt_pkg::*;
#(
   parameter int NUM_XP = 13
) (
   input  logic [NUM_XP-1:0]     xp_i,
   output logic [NUM_PULSES-1:0] pl_o
);

   function automatic logic [NUM_XP-1:0] source_mask(input int pl);
      logic [NUM_XP-1:0] m;
      m = '0;
      for (int x = 0; x < NUM_XP; x++) m[x] = xp_drives(x, pl);
      return m;
   endfunction

   for (genvar p = 0; p < NUM_PULSES; p++) begin : g_pulse
      localparam logic [NUM_XP-1:0] MASK = source_mask(p);
      assign pl_o[p] = |(xp_i & MASK);
   end

endmodule

// File: rtl/xpt_ctrl_gen.sv
module xpt_ctrl_gen
   import xpt_pkg::*;
#(
   parameter int SUB_W         = 4,
   parameter int STEP_W        = 4,
   parameter int NUM_STEPS     = 12,
   parameter int NUM_AUX       = 7,
   parameter int ADS_CODE      = 1,
   parameter int DAS_CODE      = 2,
   parameter int AUX_BASE_CODE = 3,
   parameter int AUX_BASE_STEP = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [SUB_W-1:0]                    sub_code,
   input  logic [STEP_W-1:0]                   time_step,
   output logic [ADD_XP_COUNT+NUM_AUX-1:0]     xpoint,
   output logic [NUM_PULSES-1:0]               ctrl_pulse
);

   localparam int NUM_XP     = ADD_XP_COUNT + NUM_AUX;
   localparam int NUM_GROUPS = NUM_AUX + 1;
   localparam int AUX_LAST_CODE = AUX_BASE_CODE + NUM_AUX - 1;

   // elaboration checks on the parameter set
   if (NUM_STEPS >= (1 << STEP_W)) begin : g_bad_step_w
      $error("time step field too narrow for NUM_STEPS");
   end
   if (NUM_STEPS < 11) begin : g_bad_steps
      $error("add sequence needs at least 11 time steps");
   end
   if (AUX_BASE_STEP < 1 || AUX_BASE_STEP + NUM_AUX - 1 > NUM_STEPS) begin : g_bad_aux_step
      $error("placeholder steps fall outside the cycle");
   end
   if (AUX_LAST_CODE >= (1 << SUB_W) || ADS_CODE >= (1 << SUB_W) || DAS_CODE >= (1 << SUB_W)) begin : g_bad_code
      $error("subinstruction code does not fit SUB_W");
   end
   if ((ADS_CODE >= AUX_BASE_CODE && ADS_CODE <= AUX_LAST_CODE) ||
       (DAS_CODE >= AUX_BASE_CODE && DAS_CODE <= AUX_LAST_CODE)) begin : g_code_overlap
      $error("add codes collide with placeholder codes");
   end

   logic [NUM_GROUPS-1:0] grp;
   logic [NUM_STEPS-1:0]  step_oh;
   logic [NUM_XP-1:0]     xp_next;
   logic [NUM_PULSES-1:0] pl_next;

   xpt_group_dec #(
      .SUB_W(SUB_W), .NUM_AUX(NUM_AUX), .ADS_CODE(ADS_CODE),
      .DAS_CODE(DAS_CODE), .AUX_BASE_CODE(AUX_BASE_CODE)
   ) u_grp (
      .sub_i(sub_code),
      .grp_o(grp)
   );

   xpt_step_dec #(
      .STEP_W(STEP_W), .NUM_STEPS(NUM_STEPS)
   ) u_step (
      .step_i(time_step),
      .step_o(step_oh)
   );

   xpt_cross_and #(
      .NUM_AUX(NUM_AUX), .NUM_STEPS(NUM_STEPS), .AUX_BASE_STEP(AUX_BASE_STEP)
   ) u_and (
      .grp_i(grp),
      .step_i(step_oh),
      .xp_o(xp_next)
   );

   xpt_pulse_or #(
      .NUM_XP(NUM_XP)
   ) u_or (
      .xp_i(xp_next),
      .pl_o(pl_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xpoint     <= '0;
         ctrl_pulse <= '0;
      end else begin
         xpoint     <= xp_next;
         ctrl_pulse <= pl_next;
      end
   end

endmodule

// File: rtl/xpt_ctrl_chk.sv
module xpt_ctrl_chk #(
   parameter int SUB_W         = 4,
   parameter int STEP_W        = 4,
   parameter int NUM_STEPS     = 12,
   parameter int NUM_AUX       = 7,
   parameter int ADS_CODE      = 1,
   parameter int DAS_CODE      = 2,
   parameter int AUX_BASE_CODE = 3,
   parameter int NUM_XP        = 13,
   parameter int NUM_PL        = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SUB_W-1:0]  sub_code,
   input logic [STEP_W-1:0] time_step,
   input logic [NUM_XP-1:0] xpoint,
   input logic [NUM_PL-1:0] ctrl_pulse
);

   logic is_add, is_aux, code_known, step_bad;
   assign is_add     = (sub_code == SUB_W'(ADS_CODE)) || (sub_code == SUB_W'(DAS_CODE));
   assign is_aux     = (int'(sub_code) >= AUX_BASE_CODE) && (int'(sub_code) < AUX_BASE_CODE + NUM_AUX);
   assign code_known = is_add || is_aux;
   assign step_bad   = (time_step == '0) || (int'(time_step) > NUM_STEPS);

   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (xpoint == '0 && ctrl_pulse == '0)
            else $error("outputs not zero during reset");
      end
   end

   p_t5_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_add && time_step == STEP_W'(5)) |=>
         (xpoint[1] && xpoint[2] && ctrl_pulse[0] && ctrl_pulse[1] && ctrl_pulse[2]));

   p_acc_sources_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_pulse[0] |-> (xpoint[1] || (|xpoint[NUM_XP-1:6])));

   p_undef_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !code_known |=> (xpoint == '0 && ctrl_pulse == '0));

   p_bad_step_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      step_bad |=> (xpoint == '0 && ctrl_pulse == '0));

   p_xp_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(xpoint) <= 2);

   p_sum_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_pulse[5] |-> (ctrl_pulse[6] ^ ctrl_pulse[8]));

endmodule

bind xpt_ctrl_gen xpt_ctrl_chk #(
   .SUB_W(SUB_W), .STEP_W(STEP_W), .NUM_STEPS(NUM_STEPS), .NUM_AUX(NUM_AUX),
   .ADS_CODE(ADS_CODE), .DAS_CODE(DAS_CODE), .AUX_BASE_CODE(AUX_BASE_CODE),
   .NUM_XP(xpt_pkg::ADD_XP_COUNT + NUM_AUX), .NUM_PL(xpt_pkg::NUM_PULSES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sub_code(sub_code), .time_step(time_step),
   .xpoint(xpoint), .ctrl_pulse(ctrl_pulse)
);

// File: tb/tb_xpt_ctrl_gen.sv
module tb_xpt_ctrl_gen;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  sub_code = '0;
   logic [3:0]  time_step = '0;
   logic [12:0] xpoint;
   logic [8:0]  ctrl_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xpt_ctrl_gen dut (
      .clk(clk), .rst_n(rst_n), .sub_code(sub_code), .time_step(time_step),
      .xpoint(xpoint), .ctrl_pulse(ctrl_pulse)
   );

   // independent model from the requirement text
   function automatic logic [21:0] model(input int code, input int step);
      logic [12:0] x;
      logic [8:0]  p;
      bit add;
      x = '0; p = '0;
      add = (code == 1) || (code == 2);
      if (add && step == 1)  begin x[0] = 1; p = 9'h018; end
      if (add && step == 5)  begin x[1] = 1; x[2] = 1; p = 9'h007; end
      if (add && step == 6)  begin x[3] = 1; p = 9'h060; end
      if (add && step == 8)  begin x[4] = 1; p = 9'h090; end
      if (add && step == 11) begin x[5] = 1; p = 9'h120; end
      for (int k = 0; k < 7; k++)
         if (code == 3 + k && step == 2 + k) begin x[6+k] = 1; p = 9'h001; end
      return {x, p};
   endfunction

   task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual xp=%h pl=%h expected xp=%h pl=%h",
                  req, act[21:9], act[8:0], exp[21:9], exp[8:0]);
      end
   endtask

   task automatic apply(input int code, input int step);
      @(negedge clk);
      sub_code  = 4'(code);
      time_step = 4'(step);
      @(negedge clk);
   endtask

   task automatic t_reset;
      sub_code = 4'd1; time_step = 4'd5;
      repeat (3) @(negedge clk);
      check("R1 reset", {xpoint, ctrl_pulse}, 22'h0);
      rst_n = 1'b1;
   endtask

   task automatic t_add_sequence;
      for (int s = 0; s < 16; s++) begin
         apply(1, s);
         if (s == 5) check("R4 step5 crosspoints", {xpoint, ctrl_pulse}, {13'h0006, 9'h007});
         else if (s >= 1 && s <= 12) check("R5 add step", {xpoint, ctrl_pulse}, model(1, s));
         else check("R8 bad step add", {xpoint, ctrl_pulse}, 22'h0);
      end
   endtask

   task automatic t_shared;
      for (int s = 1; s <= 12; s++) begin
         apply(2, s);
         check("R3 shared group", {xpoint, ctrl_pulse}, model(1, s));
      end
   endtask

   task automatic t_aux;
      for (int k = 0; k < 7; k++) begin
         apply(3 + k, 2 + k);
         check("R6 aux source", {xpoint, ctrl_pulse}, {13'(1 << (6 + k)), 9'h001});
         apply(3 + k, 3 + k);
         check("R9 aux wrong step", {xpoint, ctrl_pulse}, 22'h0);
      end
   endtask

   task automatic t_undefined;
      for (int c = 0; c < 16; c++) begin
         if (c >= 1 && c <= 9) continue;
         for (int s = 0; s < 16; s++) begin
            apply(c, s);
            check("R7 undefined code", {xpoint, ctrl_pulse}, 22'h0);
         end
      end
   endtask

   task automatic t_bad_steps;
      for (int c = 1; c <= 9; c++) begin
         apply(c, 0);
         check("R8 step zero", {xpoint, ctrl_pulse}, 22'h0);
         apply(c, 13 + (c % 3));
         check("R8 step high", {xpoint, ctrl_pulse}, 22'h0);
      end
   endtask

   task automatic t_latency;
      apply(1, 1);
      check("R2 first value", {xpoint, ctrl_pulse}, {13'h0001, 9'h018});
      sub_code = 4'd1; time_step = 4'd6;
      #1;
      check("R2 holds before edge", {xpoint, ctrl_pulse}, {13'h0001, 9'h018});
      @(negedge clk);
      check("R2 after edge", {xpoint, ctrl_pulse}, {13'h0008, 9'h060});
   endtask

   task automatic t_sweep;
      // random-order revisits: no dependence on the previous input
      for (int c = 15; c >= 0; c--)
         for (int s = 0; s < 16; s++) begin
            apply(c, (s * 7 + c) % 16);
            check("R10 pure function", {xpoint, ctrl_pulse}, model(c, (s * 7 + c) % 16));
         end
   endtask

   initial begin
      t_reset();
      t_add_sequence();
      t_shared();
      t_aux();
      t_undefined();
      t_bad_steps();
      t_latency();
      t_sweep();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule